// File: doc/BRIEF.md
# Pulse-Interval Serial Command Sender

This block sends 12-bit command words, one after another, over a single control line. Every bit produces a pulse of the same fixed width. The value of a bit is carried by the time from the start of its pulse to the start of the next one: a short interval means 0 and a long interval means 1. The host pushes words into a small in-order queue. The block sends them most significant bit first. Each word is set apart from the next by a long idle gap.

Transmission is paced by one free-running scheduling timer. Each time the timer expires, the block makes one decision:
- If the current word still has bits to send, it sends the next bit.
- If the word is finished and the queue is not empty, it takes the oldest word and waits one idle gap before that word's first pulse.
- If the word is finished and the queue is empty, it waits one idle gap and looks at the queue again.

All timing constants are given in clock cycles. By default they are derived from the clock frequency:
- pulse width: 250 us
- interval for a 0 bit: 1 ms
- interval for a 1 bit: 2 ms
- idle gap: 30 ms

A simulation can replace them with small values.

Top module: `pulse_cmd_tx`

## Requirements
- R1: While reset is high and in the cycle after it falls, line_o, busy_o and full_o are all low and the queue is empty. The scheduling timer restarts, so the first decision falls GAP_CYC cycles after the first clock edge with reset low.
- R2: Every pulse holds line_o high for exactly PULSE_CYC cycles. It rises one cycle after the decision that sends the bit.
- R3: Within a word, the decision after a bit falls ZERO_CYC cycles after that bit's decision when the bit is 0, and ONE_CYC cycles after it when the bit is 1. Consecutive rising edges of line_o are therefore spaced by these amounts.
- R4: A word produces exactly 12 pulses, in order from bit 11 down to bit 0. The spacing after the pulse of bit k encodes bit k.
- R5: At a decision with no bits left, a non-empty queue gives up its oldest word, and that word's first pulse starts GAP_CYC cycles later. An empty queue makes the next decision GAP_CYC cycles later.
- R6: The queue holds up to DEPTH words and releases them in write order. full_o is high exactly while DEPTH words are held.
- R7: A write made while full_o is high is dropped and changes nothing. A word taken from the queue in the same cycle does not make room for that write.
- R8: busy_o is high while the queue holds a word or a word is in flight. A word is in flight from the decision that takes it until the decision that ends its last bit interval. busy_o changes one cycle after the edge that causes the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wr_en_i | input | 1 | Write request; the word is taken at the clock edge if the queue is not full |
| wr_data_i | input | WORD_W | Command word to queue |
| line_o | output | 1 | Control line, high during each bit pulse |
| busy_o | output | 1 | Queue not empty or a word in flight |
| full_o | output | 1 | Queue holds DEPTH words |

## Verification
Each result has a fixed delay after the edge that causes it:
- A write shows up on full_o and busy_o one cycle after the edge that accepts it.
- A taken word shows no pulse until GAP_CYC cycles after the decision that took it.
- Each pulse rises one cycle after its decision and lasts PULSE_CYC cycles.
- busy_o falls one cycle after the decision that closes the final bit interval.

A behavioural reference model steps on each rising edge, using the pre-edge queue occupancy for both the load choice and write acceptance. All three outputs are compared against it at every falling edge, half a cycle away from any update. Directed checks measure pulse widths, the rising-edge intervals of a known word including the last bit's interval up to the fall of busy_o, and the number of words actually sent after a burst that overflows the queue.

// File: rtl/pct_pkg.sv
package pct_pkg;

  // Outcome of one scheduling decision
  typedef enum logic [1:0] {
    EV_WAIT = 2'd0,  // timer still running
    EV_BIT  = 2'd1,  // emit next bit of current word
    EV_LOAD = 2'd2,  // take next word from the queue
    EV_POLL = 2'd3   // nothing queued, look again later
  } pct_ev_e;

  // Circular index advance for an arbitrary depth
  function automatic int unsigned wrap_next(int unsigned idx, int unsigned depth);
    return (idx == depth - 1) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/pct_fifo.sv
module pct_fifo #(
  parameter int W     = 12,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push_req,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head_q,
  output logic         empty_q,
  output logic         full_q,
  output logic         empty_nxt
);
  import pct_pkg::*;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_idx, rd_idx, wr_idx_n, rd_idx_n;
  logic          wr_lap, rd_lap, wr_lap_n, rd_lap_n;
  logic          push, take, full_nxt;

  assign push = push_req & ~full_q;
  assign take = pop & ~empty_q;

  always_comb begin
    wr_idx_n = wr_idx;
    wr_lap_n = wr_lap;
    rd_idx_n = rd_idx;
    rd_lap_n = rd_lap;
    if (push) begin
      wr_idx_n = AW'(wrap_next(32'(wr_idx), DEPTH));
      if (wr_idx == AW'(DEPTH - 1)) wr_lap_n = ~wr_lap;
    end
    if (take) begin
      rd_idx_n = AW'(wrap_next(32'(rd_idx), DEPTH));
      if (rd_idx == AW'(DEPTH - 1)) rd_lap_n = ~rd_lap;
    end
  end

  // equal indices: empty on the same lap, full one lap apart
  assign empty_nxt = (wr_idx_n == rd_idx_n) && (wr_lap_n == rd_lap_n);
  assign full_nxt  = (wr_idx_n == rd_idx_n) && (wr_lap_n != rd_lap_n);

  // storage: single write port, registered read
  always_ff @(posedge clk) begin
    if (push) mem[wr_idx] <= push_data;
    head_q <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_idx  <= '0;
      rd_idx  <= '0;
      wr_lap  <= 1'b0;
      rd_lap  <= 1'b0;
      empty_q <= 1'b1;
      full_q  <= 1'b0;
    end else begin
      wr_idx  <= wr_idx_n;
      rd_idx  <= rd_idx_n;
      wr_lap  <= wr_lap_n;
      rd_lap  <= rd_lap_n;
      empty_q <= empty_nxt;
      full_q  <= full_nxt;
    end
  end

endmodule

// File: rtl/pct_sequencer.sv
module pct_sequencer #(
  parameter int W        = 12,
  parameter int ZERO_CYC = 8,
  parameter int ONE_CYC  = 16,
  parameter int GAP_CYC  = 40,
  parameter int TW       = 6,
  localparam int BW      = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         empty_q,
  input  logic [W-1:0] head_q,
  output logic         fire,
  output logic         pop,
  output logic         active_nxt
);
  import pct_pkg::*;

  logic [TW-1:0] tmr;
  logic [BW-1:0] bits_left;
  logic [W-1:0]  shreg;
  logic          fetch;
  logic          active;
  pct_ev_e       ev;

  always_comb begin
    ev = EV_WAIT;
    if (tmr == '0) begin
      if (bits_left != '0)  ev = EV_BIT;
      else if (!empty_q)    ev = EV_LOAD;
      else                  ev = EV_POLL;
    end
  end

  assign fire = (ev == EV_BIT);
  assign pop  = (ev == EV_LOAD);

  always_comb begin
    case (ev)
      EV_LOAD: active_nxt = 1'b1;
      EV_POLL: active_nxt = 1'b0;
      default: active_nxt = active;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr       <= TW'(GAP_CYC - 1);
      bits_left <= '0;
      shreg     <= '0;
      fetch     <= 1'b0;
      active    <= 1'b0;
    end else begin
      active <= active_nxt;
      fetch  <= (ev == EV_LOAD);
      case (ev)
        EV_WAIT: tmr <= tmr - TW'(1);
        EV_BIT: begin
          tmr       <= shreg[W-1] ? TW'(ONE_CYC - 1) : TW'(ZERO_CYC - 1);
          shreg     <= {shreg[W-2:0], 1'b0};
          bits_left <= bits_left - BW'(1);
        end
        EV_LOAD: begin
          tmr       <= TW'(GAP_CYC - 1);
          bits_left <= BW'(W);
        end
        default: tmr <= TW'(GAP_CYC - 1);
      endcase
      // head word arrives one cycle after the pop; no bit is due that soon
      if (fetch) shreg <= head_q;
    end
  end

endmodule

// File: rtl/pct_pulse.sv
module pct_pulse #(
  parameter int PULSE_CYC = 3,
  localparam int PW       = $clog2(PULSE_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic line_q
);

  logic [PW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= 1'b0;
      remain <= '0;
    end else if (fire) begin
      line_q <= 1'b1;
      remain <= PW'(PULSE_CYC - 1);
    end else if (line_q) begin
      if (remain == '0) line_q <= 1'b0;
      else              remain <= remain - PW'(1);
    end
  end

endmodule

// File: rtl/pulse_cmd_tx.sv
module pulse_cmd_tx #(
  parameter int WORD_W    = 12,
  parameter int DEPTH     = 8,
  parameter int CLK_HZ    = 250_000_000,
  parameter int PULSE_CYC = CLK_HZ / 4000,
  parameter int ZERO_CYC  = CLK_HZ / 1000,
  parameter int ONE_CYC   = 2 * ZERO_CYC,
  parameter int GAP_CYC   = 30 * ZERO_CYC
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic              line_o,
  output logic              busy_o,
  output logic              full_o
);

  localparam int TMAX = (GAP_CYC > ONE_CYC) ? GAP_CYC : ONE_CYC;
  localparam int TW   = $clog2(TMAX + 1);

  logic [WORD_W-1:0] head_q;
  logic              empty_q, empty_nxt;
  logic              fire, pop, active_nxt;
  logic              busy_q;

  pct_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk_i),
    .rst       (rst_i),
    .push_req  (wr_en_i),
    .push_data (wr_data_i),
    .pop       (pop),
    .head_q    (head_q),
    .empty_q   (empty_q),
    .full_q    (full_o),
    .empty_nxt (empty_nxt)
  );

  pct_sequencer #(
    .W(WORD_W), .ZERO_CYC(ZERO_CYC), .ONE_CYC(ONE_CYC),
    .GAP_CYC(GAP_CYC), .TW(TW)
  ) u_seq (
    .clk        (clk_i),
    .rst        (rst_i),
    .empty_q    (empty_q),
    .head_q     (head_q),
    .fire       (fire),
    .pop        (pop),
    .active_nxt (active_nxt)
  );

  pct_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk    (clk_i),
    .rst    (rst_i),
    .fire   (fire),
    .line_q (line_o)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) busy_q <= 1'b0;
    else       busy_q <= active_nxt | ~empty_nxt;
  end

  assign busy_o = busy_q;

endmodule

// File: rtl/pct_checker.sv
module pct_checker #(
  parameter int PULSE = 3,
  parameter int ZERO  = 8
) (
  input logic clk,
  input logic rst,
  input logic line,
  input logic busy,
  input logic full,
  input logic wr_en,
  input logic pop
);

  logic [31:0] hi_cnt, sp_cnt;
  logic        seen_rise;
  logic        rst_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt    <= '0;
      sp_cnt    <= '0;
      seen_rise <= 1'b0;
    end else begin
      hi_cnt <= line ? hi_cnt + 32'd1 : '0;
      if ($rose(line)) begin
        sp_cnt    <= 32'd1;
        seen_rise <= 1'b1;
      end else if (sp_cnt != '1) begin
        sp_cnt <= sp_cnt + 32'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst_d) begin
      AST_RESET_IDLE: assert (!line && !busy && !full); // R1
    end
  end

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst) $fell(line) |-> hi_cnt == 32'(PULSE)); // R2
  AST_MIN_SPACING: assert property (@(posedge clk) disable iff (rst) ($rose(line) && seen_rise) |-> sp_cnt >= 32'(ZERO)); // R3
  AST_FULL_BUSY: assert property (@(posedge clk) disable iff (rst) full |-> busy); // R6
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst) (full && wr_en && !pop) |=> full); // R7
  AST_PULSE_IN_BUSY: assert property (@(posedge clk) disable iff (rst) line |-> busy); // R8

endmodule

bind pulse_cmd_tx pct_checker #(.PULSE(PULSE_CYC), .ZERO(ZERO_CYC)) u_chk (
  .clk   (clk_i),
  .rst   (rst_i),
  .line  (line_o),
  .busy  (busy_o),
  .full  (full_o),
  .wr_en (wr_en_i),
  .pop   (pop)
);

// File: tb/pulse_cmd_tx_test.sv
module pulse_cmd_tx_test;

  localparam int W     = 12;
  localparam int DEPTH = 8;
  localparam int PULSE = 3;
  localparam int ZERO  = 8;
  localparam int ONE   = 16;
  localparam int GAP   = 40;
  localparam int LIMIT = 150000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         line, busy, full;

  always #2 clk = ~clk;

  pulse_cmd_tx #(
    .WORD_W(W), .DEPTH(DEPTH), .PULSE_CYC(PULSE),
    .ZERO_CYC(ZERO), .ONE_CYC(ONE), .GAP_CYC(GAP)
  ) uut (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .line_o(line), .busy_o(busy), .full_o(full)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit run_chk = 1'b0;

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int           m_tmr, m_bits, m_pl;
  logic [W-1:0] m_word;
  bit           m_act;
  logic [W-1:0] m_q[$];
  int           m_written = 0;
  int           m_accepted = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_tmr  = GAP - 1;
      m_bits = 0;
      m_pl   = 0;
      m_act  = 1'b0;
      m_word = '0;
      m_q.delete();
    end else begin
      int sz0;
      sz0 = m_q.size();
      if (m_pl > 0) m_pl--;
      if (m_tmr != 0) begin
        m_tmr--;
      end else if (m_bits > 0) begin
        m_pl   = PULSE;
        m_tmr  = (m_word[W-1] ? ONE : ZERO) - 1;
        m_word = m_word << 1;
        m_bits--;
      end else if (sz0 > 0) begin
        m_word = m_q.pop_front();
        m_bits = W;
        m_act  = 1'b1;
        m_tmr  = GAP - 1;
      end else begin
        m_act = 1'b0;
        m_tmr = GAP - 1;
      end
      if (wr_en) begin
        m_written++;
        if (sz0 < DEPTH) begin
          m_q.push_back(wr_data);
          m_accepted++;
        end
      end
    end
  end

  // ---------------- monitor at falling edge ----------------
  int  rise_t[$];
  int  last_rise = 0;
  bit  have_rise = 1'b0;
  int  word_starts = 0;
  int  hi_run = 0;
  int  busy_fall_t = 0;
  bit  line_prev = 1'b0;
  bit  busy_prev = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (run_chk) begin
      check("R2/R3/R5 line vs model", int'(line), int'(m_pl > 0));
      check("R8 busy vs model", int'(busy), int'(m_act || m_q.size() > 0));
      check("R6/R7 full vs model", int'(full), int'(m_q.size() == DEPTH));
    end
    if (line && !line_prev) begin
      rise_t.push_back(cyc);
      if (!have_rise || (cyc - last_rise) > ONE) word_starts++;
      have_rise = 1'b1;
      last_rise = cyc;
    end
    if (line) hi_run++;
    else if (line_prev) begin
      check("R2 pulse width", hi_run, PULSE);
      hi_run = 0;
    end
    if (!busy && busy_prev) busy_fall_t = cyc;
    line_prev = line;
    busy_prev = busy;
    if (cyc > LIMIT) begin
      fails++;
      $display("FAIL R5 watchdog: got %0d cycles expected below %0d", cyc, LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic write_word(logic [W-1:0] w);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = w;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [W-1:0] w;
    int starts0, acc0, wr0;

    // R1: reset state
    repeat (4) @(negedge clk);
    check("R1 line in reset", int'(line), 0);
    check("R1 busy in reset", int'(busy), 0);
    check("R1 full in reset", int'(full), 0);
    rst = 1'b0;
    @(negedge clk);
    run_chk = 1'b1;
    check("R1 line after reset", int'(line), 0);
    check("R1 busy after reset", int'(busy), 0);
    repeat (5) @(negedge clk);

    // R3/R4: one known word, intervals decoded MSB first
    w = 12'hA5C;
    rise_t.delete();
    write_word(w);
    check("R8 busy after write", int'(busy), 1);
    wait_idle();
    check("R4 pulse count", rise_t.size(), W);
    if (rise_t.size() == W) begin
      for (int k = 0; k < W - 1; k++)
        check($sformatf("R3/R4 interval after bit %0d", W - 1 - k),
              rise_t[k + 1] - rise_t[k], w[W - 1 - k] ? ONE : ZERO);
      check("R3/R4 last bit interval to busy fall", busy_fall_t - rise_t[W - 1],
            w[0] ? ONE : ZERO);
    end

    // R5: two back-to-back words, all ones then all zeros
    starts0 = word_starts;
    write_word(12'hFFF);
    write_word(12'h000);
    wait_idle();
    check("R5 words sent back to back", word_starts - starts0, 2);

    // R6/R7: burst that overflows the queue
    starts0 = word_starts;
    acc0    = m_accepted;
    wr0     = m_written;
    @(negedge clk);
    for (int i = 0; i < DEPTH + 2; i++) begin
      wr_en   = 1'b1;
      wr_data = W'(12'h100 + i);
      @(negedge clk);
    end
    wr_en = 1'b0;
    check("R6 full after burst", int'(full), 1);
    check("R7 writes dropped when full", int'((m_written - wr0) > (m_accepted - acc0)), 1);
    wait_idle();
    check("R7 only accepted words sent", word_starts - starts0, m_accepted - acc0);
    check("R6 full cleared when drained", int'(full), 0);

    // R5/R8: writes arriving while a word is in flight
    starts0 = word_starts;
    write_word(12'h3C5);
    repeat (70) @(negedge clk);
    write_word(12'h801);
    repeat (37) @(negedge clk);
    write_word(12'h7FE);
    wait_idle();
    check("R5 words sent with mid-flight writes", word_starts - starts0, 3);
    check("R8 busy low when idle", int'(busy), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule